// File: doc/BRIEF.md
# Smart Card Character Transmitter

This block sends 8-bit characters to a smart card over a single half-duplex data line. Each character goes out as a low start bit, eight data bits and a parity bit, with each bit lasting one elementary time unit (ETU) counted in card-clock periods. After the parity bit the block lets go of the line and listens for the card. A card that rejects the character pulls the line low in the guard window. The block then flags the error and sends the same character again, and it keeps doing so until the card accepts it.

Software loads a character through a write strobe, which also clears the transmit-end flag. The block sets the flag again once the character is accepted. When the flag sets depends on a guard-mode input: in normal mode it waits out the full guard time, and in early mode it reports completion as soon as the error sample finds no error. A free-running divider makes the card clock from the module clock. The data line is driven only while bits are on the wire and sits in high impedance at all other times. The transmit-end flag and the error flag each raise an interrupt request when the matching enable is set.

Top module: `smartcard_tx`

## Requirements
- R1: A card-clock tick occurs every `rateDiv`+1 module clocks while `scEnable` is 1. `sckOut` toggles on each tick when `clkEn` is 1, and it is held low when `clkEn` is 0 or `scEnable` is 0.
- R2: `dataOe` is 1 only during the start, data and parity bits of a character in flight. It is 0 after reset, while idle, while `scEnable` is 0, and in the guard window from 10.0 ETU after the start edge.
- R3: A character starts on the clock after a pending write is seen with `scEnable`=1, `txEn`=1 and `rxEn`=0. Bit k (k=0 start, 1..8 data, 9 parity) is driven from 2k to 2k+2 half-ETUs after the start, one ETU being `ETU_TICKS` card-clock ticks. The start bit is always driven low.
- R4: The parity line bit is the XOR of the 8 data bits when `oddParity`=0, and the inverse of that XOR when `oddParity`=1.
- R5: With `msbFirst`=0 the data bits go out bit 0 first. With `msbFirst`=1 they go out bit 7 first.
- R6: With `invertLine`=1 every data bit and the parity bit are inverted on the line. The start bit stays low.
- R7: The line is sampled exactly 11.0 ETU after the start edge. A low level there sets `ersFlag` and the same byte is sent again, starting 13.0 ETU after the previous start edge. This repeats until a sample reads high.
- R8: `tendFlag` is 1 after reset and clears on `wrData`. After an error-free sample it sets 12.5 ETU after the start edge when `gmMode`=0, or 11.0 ETU after it when `gmMode`=1, and the line then stays released.
- R9: `txiReq` equals `tendFlag` AND `txIe`. `eriReq` equals `ersFlag` AND `rxIe`.
- R10: While `rxEn`=1, `txEn`=0 or `scEnable`=0, no character starts and any character in flight is dropped. A pending write stays pending and is sent once the enables allow it.
- R11: `ersFlag` stays set until an `ersClr` pulse clears it. A new error in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Active-low synchronous reset |
| scEnable | input | 1 | Smart card mode on; the pins belong to the block |
| txEn | input | 1 | Transmit enable |
| rxEn | input | 1 | Receive enable; blocks transmission when set |
| clkEn | input | 1 | Drive the card clock on sckOut |
| gmMode | input | 1 | Early completion (11.0 ETU) when 1 |
| oddParity | input | 1 | Odd parity when 1, even when 0 |
| msbFirst | input | 1 | Bit 7 first when 1 |
| invertLine | input | 1 | Invert data and parity levels on the line |
| txIe | input | 1 | Transmit-end interrupt enable |
| rxIe | input | 1 | Error interrupt enable |
| rateDiv | input | DIV_W | Module clocks per card-clock tick, minus one |
| wrData | input | 1 | Strobe: load wrByte as the next character |
| wrByte | input | 8 | Character to send |
| ersClr | input | 1 | Strobe: clear the error flag |
| dataIn | input | 1 | Level read back from the data line |
| dataOut | output | 1 | Level to drive onto the data line |
| dataOe | output | 1 | Output enable for the data line (0 = high impedance) |
| sckOut | output | 1 | Card clock |
| tendFlag | output | 1 | Character accepted / transmitter idle |
| ersFlag | output | 1 | Card reported a character error |
| txiReq | output | 1 | Transmit-end interrupt request |
| eriReq | output | 1 | Error interrupt request |

## Verification
The bench targets the guard window. An error-sample point off by one tick would miss a card pull that starts half an ETU before the sample, or would catch the line still being driven by the parity bit. A wrong restart point would shift every bit of the retransmitted character. It checks both guard modes, with and without an error, because completing at 12.5 ETU in early mode, or reporting completion after a rejected character, would break the next write. It also runs bit order, inversion and both parity senses against bytes whose two halves differ. Finally it holds a write behind `rxEn`, since a design that ignored the conflict would drive the line while the card may be driving it.

// File: rtl/sctx_pkg.sv
package sctx_pkg;
  // Frame positions counted in half-ETUs from the start edge; the value is
  // the half-unit that is completing when the event fires.
  localparam int POS_W = 5;
  localparam logic [POS_W-1:0] DRIVE_END   = 5'd20; // first guard half
  localparam logic [POS_W-1:0] SAMPLE_POS  = 5'd21; // completes at 11.0 ETU
  localparam logic [POS_W-1:0] GUARD0_POS  = 5'd24; // completes at 12.5 ETU
  localparam logic [POS_W-1:0] RESTART_POS = 5'd25; // completes at 13.0 ETU

  typedef struct packed {
    logic       load;    // copy the pending byte into the frame register
    logic       drive;   // a bit is on the wire
    logic [3:0] bitIdx;  // 0 start, 1..8 data, 9 parity
  } sctx_strobe_t;
endpackage

// File: rtl/sctx_datapath.sv
module sctx_datapath
  import sctx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             scEnable,
  input  logic             clkEn,
  input  logic [DIV_W-1:0] rateDiv,
  input  logic             wrData,
  input  logic [7:0]       wrByte,
  input  logic             oddParity,
  input  logic             msbFirst,
  input  logic             invertLine,
  input  sctx_strobe_t     strb,
  output logic             tick,
  output logic             sckOut,
  output logic             dataOut,
  output logic             dataOe
);
  localparam int BYTE_W = 8;

  logic [DIV_W-1:0]  divCnt;
  logic              sckReg;
  logic [BYTE_W-1:0] tdrReg;
  logic [BYTE_W-1:0] frameByte;
  logic [BYTE_W-1:0] revByte;
  logic [BYTE_W-1:0] orderedByte;
  logic [3:0]        dataIdx;
  logic              parityBit;
  logic              lineBit;

  assign tick = scEnable && (divCnt == rateDiv);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      sckReg <= 1'b0;
    end else if (!scEnable) begin
      divCnt <= '0;
      sckReg <= 1'b0;
    end else if (tick) begin
      divCnt <= '0;
      sckReg <= !sckReg;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign sckOut = sckReg && clkEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tdrReg    <= '0;
      frameByte <= '0;
    end else begin
      if (wrData)    tdrReg    <= wrByte;
      if (strb.load) frameByte <= tdrReg;
    end
  end

  for (genvar i = 0; i < BYTE_W; i++) begin : g_rev
    assign revByte[i] = frameByte[BYTE_W-1-i];
  end

  assign orderedByte = msbFirst ? revByte : frameByte;
  assign parityBit   = (^frameByte) ^ oddParity;
  assign dataIdx     = strb.bitIdx - 4'd1;

  always_comb begin
    case (strb.bitIdx)
      4'd0:    lineBit = 1'b0;
      4'd9:    lineBit = parityBit ^ invertLine;
      default: lineBit = orderedByte[dataIdx[2:0]] ^ invertLine;
    endcase
  end

  assign dataOe  = strb.drive;
  assign dataOut = strb.drive ? lineBit : 1'b1;

  assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> (!tick || rateDiv == '0));

  assert_start_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && strb.bitIdx == 4'd0) |-> !dataOut);

  assert_frame_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(frameByte));
endmodule

// File: rtl/sctx_control.sv
module sctx_control
  import sctx_pkg::*;
#(
  parameter int ETU_TICKS = 372
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         scEnable,
  input  logic         txEn,
  input  logic         rxEn,
  input  logic         gmMode,
  input  logic         wrData,
  input  logic         ersClr,
  input  logic         tick,
  input  logic         dataIn,
  output sctx_strobe_t strb,
  output logic         tendFlag,
  output logic         ersFlag
);
  localparam int HALF_TICKS = ETU_TICKS / 2;
  localparam int SUB_W      = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(HALF_TICKS - 1);

  logic             active;
  logic             pending;
  logic             errSeen;
  logic [POS_W-1:0] hPos;
  logic [SUB_W-1:0] subCnt;
  logic             blocked;
  logic             startNow;
  logic             halfDone;

  assign blocked  = !scEnable || !txEn || rxEn;
  assign startNow = !blocked && !active && pending;
  assign halfDone = active && tick && (subCnt == SUB_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      pending  <= 1'b0;
      errSeen  <= 1'b0;
      hPos     <= '0;
      subCnt   <= '0;
      tendFlag <= 1'b1;
      ersFlag  <= 1'b0;
    end else begin
      if (ersClr) ersFlag <= 1'b0;
      if (blocked) begin
        active <= 1'b0;
      end else if (startNow) begin
        active  <= 1'b1;
        pending <= 1'b0;
        errSeen <= 1'b0;
        hPos    <= '0;
        subCnt  <= '0;
      end else if (active && tick) begin
        if (subCnt != SUB_LAST) begin
          subCnt <= subCnt + 1'b1;
        end else begin
          subCnt <= '0;
          if (hPos == SAMPLE_POS) begin
            if (!dataIn) begin
              ersFlag <= 1'b1;
              errSeen <= 1'b1;
              hPos    <= hPos + 1'b1;
            end else if (gmMode) begin
              tendFlag <= 1'b1;
              active   <= 1'b0;
            end else begin
              hPos <= hPos + 1'b1;
            end
          end else if (hPos == GUARD0_POS && !errSeen) begin
            tendFlag <= 1'b1;
            active   <= 1'b0;
          end else if (hPos == RESTART_POS) begin
            hPos    <= '0;
            errSeen <= 1'b0;
          end else begin
            hPos <= hPos + 1'b1;
          end
        end
      end
      if (wrData) begin
        pending  <= 1'b1;
        tendFlag <= 1'b0;
      end
    end
  end

  assign strb.load   = startNow;
  assign strb.drive  = active && (hPos < DRIVE_END);
  assign strb.bitIdx = hPos[4:1];

  assert_no_clash_R10: assert property (@(posedge clk) disable iff (!rstN)
    rxEn |=> !active);

  assert_tend_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrData |=> !tendFlag);

  assert_ers_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    (ersFlag && !ersClr) |=> ersFlag);

  assert_guard_release_R2: assert property (@(posedge clk) disable iff (!rstN)
    (halfDone && hPos == SAMPLE_POS) |-> !strb.drive);
endmodule

// File: rtl/smartcard_tx.sv
module smartcard_tx
  import sctx_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int ETU_TICKS = 372
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             scEnable,
  input  logic             txEn,
  input  logic             rxEn,
  input  logic             clkEn,
  input  logic             gmMode,
  input  logic             oddParity,
  input  logic             msbFirst,
  input  logic             invertLine,
  input  logic             txIe,
  input  logic             rxIe,
  input  logic [DIV_W-1:0] rateDiv,
  input  logic             wrData,
  input  logic [7:0]       wrByte,
  input  logic             ersClr,
  input  logic             dataIn,
  output logic             dataOut,
  output logic             dataOe,
  output logic             sckOut,
  output logic             tendFlag,
  output logic             ersFlag,
  output logic             txiReq,
  output logic             eriReq
);
  sctx_strobe_t strb;
  logic         tick;

  sctx_control #(.ETU_TICKS(ETU_TICKS)) ctrl_i (
    .clk(clk), .rstN(rstN), .scEnable(scEnable), .txEn(txEn), .rxEn(rxEn),
    .gmMode(gmMode), .wrData(wrData), .ersClr(ersClr), .tick(tick),
    .dataIn(dataIn), .strb(strb), .tendFlag(tendFlag), .ersFlag(ersFlag)
  );

  sctx_datapath #(.DIV_W(DIV_W)) dp_i (
    .clk(clk), .rstN(rstN), .scEnable(scEnable), .clkEn(clkEn),
    .rateDiv(rateDiv), .wrData(wrData), .wrByte(wrByte),
    .oddParity(oddParity), .msbFirst(msbFirst), .invertLine(invertLine),
    .strb(strb), .tick(tick), .sckOut(sckOut), .dataOut(dataOut),
    .dataOe(dataOe)
  );

  assign txiReq = tendFlag && txIe;
  assign eriReq = ersFlag && rxIe;

  assert_irq_map_R9: assert property (@(posedge clk) disable iff (!rstN)
    (txiReq == (tendFlag && txIe)) && (eriReq == (ersFlag && rxIe)));
endmodule

// File: tb/smartcard_tx_tb_top.sv
`timescale 1ns/1ps
module smartcard_tx_tb_top;
  localparam int ETU = 4;
  localparam int H   = ETU / 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scEnable = 1'b0, txEn = 1'b0, rxEn = 1'b0, clkEn = 1'b0, gmMode = 1'b0;
  logic oddParity = 1'b0, msbFirst = 1'b0, invertLine = 1'b0;
  logic txIe = 1'b0, rxIe = 1'b0, wrData = 1'b0, ersClr = 1'b0;
  logic [7:0] rateDiv = 8'd1;
  logic [7:0] wrByte = 8'd0;
  logic dataIn, dataOut, dataOe, sckOut, tendFlag, ersFlag, txiReq, eriReq;
  logic cardPull = 1'b0;

  int errors = 0, checks = 0;
  bit cmpOn = 1'b0, finished = 1'b0;
  string curReq = "R3";

  always #10 clk = !clk;

  assign dataIn = dataOe ? dataOut : !cardPull;

  smartcard_tx #(.DIV_W(8), .ETU_TICKS(ETU)) dut_i (
    .clk(clk), .rstN(rstN), .scEnable(scEnable), .txEn(txEn), .rxEn(rxEn),
    .clkEn(clkEn), .gmMode(gmMode), .oddParity(oddParity),
    .msbFirst(msbFirst), .invertLine(invertLine), .txIe(txIe), .rxIe(rxIe),
    .rateDiv(rateDiv), .wrData(wrData), .wrByte(wrByte), .ersClr(ersClr),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe), .sckOut(sckOut),
    .tendFlag(tendFlag), .ersFlag(ersFlag), .txiReq(txiReq), .eriReq(eriReq)
  );

  // Behavioural reference: time since start counted in card ticks.
  int  mDiv, mT, injectLeft = 0;
  bit  mSck, mAct, mPend, mTend, mErs, mErr;
  logic [7:0] mTdr, mByte;

  always @(posedge clk) begin
    bit tk;
    if (!rstN) begin
      mDiv = 0; mSck = 0; mAct = 0; mPend = 0; mTend = 1; mErs = 0;
      mErr = 0; mT = 0; mTdr = 0; mByte = 0;
    end else begin
      tk = scEnable && (mDiv == int'(rateDiv));
      if (!scEnable) begin mDiv = 0; mSck = 0; end
      else if (tk) begin mDiv = 0; mSck = !mSck; end
      else mDiv++;
      if (ersClr) mErs = 0;
      if (!scEnable || !txEn || rxEn) mAct = 0;
      else if (!mAct && mPend) begin
        mAct = 1; mT = 0; mPend = 0; mByte = mTdr; mErr = 0;
      end else if (mAct && tk) begin
        mT++;
        if (mT == 22*H) begin           // 11.0 ETU sample
          if (cardPull) begin mErs = 1; mErr = 1; injectLeft--; end
          else if (gmMode) begin mTend = 1; mAct = 0; end
        end else if (mT == 25*H && !mErr) begin  // 12.5 ETU
          mTend = 1; mAct = 0;
        end else if (mT == 26*H) begin  // 13.0 ETU restart
          mT = 0; mErr = 0;
        end
      end
      if (wrData) begin mTdr = wrByte; mPend = 1; mTend = 0; end
    end
  end

  always @(negedge clk)
    cardPull <= mAct && (mT >= 21*H) && (mT < 23*H) && (injectLeft > 0);

  function automatic logic expLine();
    int b = (mT / H) / 2;
    logic v;
    if (b == 0) return 1'b0;
    if (b == 9) v = (^mByte) ^ oddParity;
    else v = msbFirst ? mByte[8-b] : mByte[b-1];
    return v ^ invertLine;
  endfunction

  task automatic cmp(string what, string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) if (cmpOn) begin
    logic eOe;
    #5;
    eOe = mAct && (mT / H) < 20;
    cmp("dataOe", "R2", dataOe, eOe);
    if (eOe) cmp("dataOut", curReq, dataOut, expLine());
    cmp("sckOut", "R1", sckOut, mSck && clkEn);
    cmp("tendFlag", "R8", tendFlag, mTend);
    cmp("ersFlag", "R7", ersFlag, mErs);
    cmp("txiReq", "R9", txiReq, mTend && txIe);
    cmp("eriReq", "R9", eriReq, mErs && rxIe);
  end

  task automatic sendByte(logic [7:0] b);
    @(negedge clk); wrByte = b; wrData = 1'b1;
    @(negedge clk); wrData = 1'b0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (!(mTend && !mAct && !mPend) && n < 20000) begin
      @(negedge clk); n++;
    end
    checks++;
    if (n >= 20000) begin errors++; $display("FAIL %s waitDone: actual=busy expected=idle", curReq); end
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #3000000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state: R8 tend set, R2 line released, R11 no error
    cmp("tendFlag reset", "R8", tendFlag, 1'b1);
    cmp("dataOe reset", "R2", dataOe, 1'b0);
    cmp("ersFlag reset", "R11", ersFlag, 1'b0);
    cmpOn = 1'b1;
    scEnable = 1'b1; txEn = 1'b1; clkEn = 1'b1; txIe = 1'b1;
    repeat (4) @(negedge clk);

    curReq = "R3"; sendByte(8'hA5); waitDone();                 // R3 even, lsb first
    curReq = "R4"; oddParity = 1'b1; sendByte(8'h3C); waitDone(); // R4 odd parity
    curReq = "R5"; msbFirst = 1'b1; sendByte(8'h1E); waitDone();  // R5 msb first
    curReq = "R6"; invertLine = 1'b1; gmMode = 1'b1;              // R6 and R8 early mode
    sendByte(8'h01); waitDone();

    curReq = "R7"; invertLine = 1'b0; msbFirst = 1'b0; gmMode = 1'b0;
    rxIe = 1'b1; injectLeft = 1; sendByte(8'hC3); waitDone();     // R7 one retry
    cmp("ersFlag after retry", "R7", ersFlag, 1'b1);
    cmp("eriReq after retry", "R9", eriReq, 1'b1);
    @(negedge clk); ersClr = 1'b1; @(negedge clk); ersClr = 1'b0;
    @(negedge clk);
    cmp("ersFlag cleared", "R11", ersFlag, 1'b0);

    gmMode = 1'b1; injectLeft = 2; sendByte(8'h5A); waitDone();   // R7 two retries, early mode

    curReq = "R10"; rxEn = 1'b1; gmMode = 1'b0; sendByte(8'h77);
    repeat (150) @(negedge clk);
    cmp("no start under rxEn", "R10", dataOe, 1'b0);
    cmp("tend held low", "R10", tendFlag, 1'b0);
    rxEn = 1'b0; waitDone();

    curReq = "R1"; rateDiv = 8'd2; sendByte(8'h99);               // R1 divider and gating
    repeat (30) @(negedge clk); clkEn = 1'b0;
    repeat (30) @(negedge clk); clkEn = 1'b1;
    waitDone();

    curReq = "R10"; sendByte(8'hF0); repeat (40) @(negedge clk);  // abort mid-frame
    txEn = 1'b0; repeat (10) @(negedge clk); txEn = 1'b1;
    sendByte(8'h0F); waitDone();

    cmpOn = 1'b0; finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule